// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single receive line. It examines the line on a 16x oversampling enable. A falling edge on the line is accepted as a start bit only if the line is still low at mid-bit. Each later bit is then sampled at its centre. The bit count, parity enable and parity sense come from static control inputs. Every completed character goes into a receive queue together with its own break, framing-error and parity-error flags. The queue holds 64 characters, or a single character when queuing is switched off.

A line that stays low for the whole character, including the stop position, is reported as a line break and not as data. The block loads one zero entry marked as a break, then waits for the line to return high before it looks for a new start bit. When the queue cannot accept a finished character, the character is dropped and a one-cycle overrun pulse is raised. With automatic flow control enabled, the request-to-send output falls as the queue nears full and rises again once it has drained past a lower threshold. This throttles the remote sender. The baud-rate divider that makes the oversampling enable lives outside this block.

Top module: `serial_rx_unit`

## Requirements
- R1: `len_sel` selects the character length: code 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits are taken at mid-bit, least significant first, and land in `rd_data` from bit 0 upward, with the unused upper bits reading 0. Each finished character makes exactly one queue entry.
- R2: With `parity_on` high, one parity bit follows the data bits. `rd_parity_err` is set when the count of ones across the data and parity bits is odd with `parity_odd` low, or even with `parity_odd` high. With `parity_on` low, the flag is always 0.
- R3: A low level on the line starts a character only if the line is still low 8 oversampling ticks later. Otherwise the receiver returns to idle and stores nothing.
- R4: If the stop bit samples low and the character is not a break, the data is stored with `rd_frame_err` set and `rd_break` clear.
- R5: If the start, data, parity and stop positions all sample low, one entry is stored with `rd_data` = 0, `rd_break` = 1 and both error flags 0. No further entry is made until the line has gone high and a new start bit arrives.
- R6: With `fifo_on` high, the queue holds up to 64 entries and returns them in arrival order. The head entry is visible on the read outputs while `rx_avail` is high, and a one-cycle `rd_en` removes it. `fifo_level` gives the number of stored entries.
- R7: With `fifo_on` low, the queue holds one entry only.
- R8: A character that finishes while the queue is full is discarded. `overrun` then pulses high for exactly one cycle, and the stored entries and `fifo_level` stay unchanged.
- R9: With `auto_rts` high, `rts` goes low one cycle after `fifo_level` reaches 60 or more. It returns high one cycle after the level falls below 56, and holds its value in between. With `auto_rts` low, `rts` is 1.
- R10: The receiver advances only on clock edges where `tick16` is high. One bit period is 16 such ticks.
- R11: After reset, `rx_avail` = 0, `fifo_level` = 0, `overrun` = 0 and `rts` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rx_in | input | 1 | Serial receive line, idle high |
| len_sel | input | 2 | Data bits per character minus 5 |
| parity_on | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| fifo_on | input | 1 | 1 = 64-entry queue, 0 = single holding entry |
| auto_rts | input | 1 | Enable automatic request-to-send |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry data |
| rd_break | output | 1 | Head entry is a line break |
| rd_frame_err | output | 1 | Head entry had a low stop bit |
| rd_parity_err | output | 1 | Head entry failed the parity check |
| rx_avail | output | 1 | Queue not empty |
| fifo_level | output | 7 | Number of stored entries |
| overrun | output | 1 | One-cycle pulse when a character is dropped |
| rts | output | 1 | Request-to-send, high = ready to receive |

## Verification
The hardest state to reach is a full queue that is still receiving. It needs sixty-four characters delivered without a single read. During that fill the bench watches `rts` fall at the sixtieth entry, and it sends one extra character to provoke the overrun. It then drains the queue entry by entry, checking both the arrival order and the point where `rts` comes back. Break handling and false-start rejection need line levels that no legal character produces, so the bench drives the line directly: it holds the line low across a whole character time, and it sends a short low glitch.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rx_s,
  input  logic [1:0] len_code,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     push,
  output rx_char_t push_char
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    shreg_q, shreg_d;
  logic          zero_q, zero_d;
  logic          par_q, par_d;
  logic [2:0]    last_bit;

  assign last_bit = {1'b0, len_code} + 3'd4;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bit_d     = bit_q;
    shreg_d   = shreg_q;
    zero_d    = zero_q;
    par_d     = par_q;
    push      = 1'b0;
    push_char = '0;
    if (tick) begin
      case (state_q)
        ST_IDLE: begin
          if (!rx_s) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == MID) begin
            if (!rx_s) begin
              state_d = ST_DATA;
              cnt_d   = '0;
              bit_d   = '0;
              shreg_d = '0;
              zero_d  = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d          = '0;
            shreg_d[bit_q] = rx_s;
            zero_d         = zero_q & ~rx_s;
            if (bit_q == last_bit) state_d = par_en ? ST_PAR : ST_STOP;
            else                   bit_d   = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            par_d   = rx_s;
            zero_d  = zero_q & ~rx_s;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            push  = 1'b1;
            if (!rx_s && zero_q) begin
              push_char.brk = 1'b1;
              state_d       = ST_HOLD;
            end else begin
              push_char.data = shreg_q;
              push_char.fe   = ~rx_s;
              push_char.pe   = par_en & ((^shreg_q ^ par_q) != par_odd);
              state_d        = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (rx_s) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      zero_q  <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      zero_q  <= zero_d;
      par_q   <= par_d;
    end
  end

  // R1
  single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  // R5
  break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !rx_s) |=> (state_q == ST_HOLD && !push));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     single,
  input  logic     wr,
  input  rx_char_t wdata,
  input  logic     rd,
  output rx_char_t rdata,
  output logic [AW:0] count,
  output logic     avail,
  output logic     ovr
);
  rx_char_t      mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          full, accept, pop;

  assign full   = single ? (cnt_q != '0) : (cnt_q == (AW+1)'(DEPTH));
  assign accept = wr & ~full;
  assign pop    = rd & (cnt_q != '0);

  always_comb begin
    wp_d  = accept ? wp_q + 1'b1 : wp_q;
    rp_d  = pop ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q + (AW+1)'(accept) - (AW+1)'(pop);
    ovr_d = wr & full;
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  assign rdata = mem_q[rp_q];
  assign count = cnt_q;
  assign avail = (cnt_q != '0);
  assign ovr   = ovr_q;

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  // R8
  drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !rd) |=> ($stable(count) && ovr));
endmodule

// File: rtl/rx_rts_ctrl.sv
module rx_rts_ctrl #(
  parameter int DEPTH  = 64,
  parameter int OFF_AT = 60,
  parameter int ON_BELOW = 56,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW:0] level,
  input  logic        auto_en,
  output logic        rts
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (level >= (AW+1)'(OFF_AT))        hold_d = 1'b0;
    else if (level < (AW+1)'(ON_BELOW))  hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= hold_d;
  end

  assign rts = ~auto_en | hold_q;

  // R9
  rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && level >= (AW+1)'(OFF_AT)) |=> (!rts || !auto_en));

  // R9
  rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level < (AW+1)'(ON_BELOW)) |=> rts);
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DEPTH    = 64,
  parameter int RTS_OFF  = 60,
  parameter int RTS_ON   = 56,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_in,
  input  logic [1:0]  len_sel,
  input  logic        parity_on,
  input  logic        parity_odd,
  input  logic        fifo_on,
  input  logic        auto_rts,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        rd_break,
  output logic        rd_frame_err,
  output logic        rd_parity_err,
  output logic        rx_avail,
  output logic [AW:0] fifo_level,
  output logic        overrun,
  output logic        rts
);
  logic     sync1_q, sync2_q;
  logic     push;
  rx_char_t push_char, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rx_in;
      sync2_q <= sync1_q;
    end
  end

  rx_framer #(.OSR(OSR)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .rx_s     (sync2_q),
    .len_code (len_sel),
    .par_en   (parity_on),
    .par_odd  (parity_odd),
    .push     (push),
    .push_char(push_char)
  );

  rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .single(~fifo_on),
    .wr    (push),
    .wdata (push_char),
    .rd    (rd_en),
    .rdata (head),
    .count (fifo_level),
    .avail (rx_avail),
    .ovr   (overrun)
  );

  rx_rts_ctrl #(.DEPTH(DEPTH), .OFF_AT(RTS_OFF), .ON_BELOW(RTS_ON)) u_rts (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (fifo_level),
    .auto_en(auto_rts),
    .rts    (rts)
  );

  assign rd_data       = head.data;
  assign rd_break      = head.brk;
  assign rd_frame_err  = head.fe;
  assign rd_parity_err = head.pe;
endmodule

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic       parity_on = 1'b0;
  logic       parity_odd = 1'b0;
  logic       fifo_on = 1'b1;
  logic       auto_rts = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_break, rd_frame_err, rd_parity_err, rx_avail, overrun, rts;
  logic [6:0] fifo_level;

  int checks = 0;
  int errors = 0;
  int ovr_seen = 0;
  bit done = 0;
  localparam int BITCLK = 32;  // 16 ticks, one tick every 2 clocks (R10)

  serial_rx_unit uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .len_sel(len_sel), .parity_on(parity_on), .parity_odd(parity_odd),
    .fifo_on(fifo_on), .auto_rts(auto_rts), .rd_en(rd_en),
    .rd_data(rd_data), .rd_break(rd_break), .rd_frame_err(rd_frame_err),
    .rd_parity_err(rd_parity_err), .rx_avail(rx_avail),
    .fifo_level(fifo_level), .overrun(overrun), .rts(rts)
  );

  always #10 clk = ~clk;
  always @(posedge clk) tick16 <= ~tick16;
  always @(negedge clk) if (overrun) ovr_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input int clocks);
    rx_in = b;
    repeat (clocks) @(negedge clk);
  endtask

  // pmode: 0 none, 1 even, 2 odd
  task automatic send(input int data, input int nbits, input int pmode,
                      input bit bad_par, input bit stop_ok);
    int ones;
    logic p;
    ones = 0;
    drive_bit(1'b0, BITCLK);
    for (int i = 0; i < nbits; i++) begin
      drive_bit(data[i], BITCLK);
      ones += data[i];
    end
    if (pmode != 0) begin
      p = (ones % 2 == 1);
      if (pmode == 2) p = ~p;
      drive_bit(p ^ bad_par, BITCLK);
    end
    if (stop_ok) drive_bit(1'b1, BITCLK);
    else begin
      drive_bit(1'b0, 20);
      drive_bit(1'b1, 44);
    end
    drive_bit(1'b1, 8);
  endtask

  task automatic pop_check(input string req, input int d, input int brk,
                           input int fe, input int pe);
    chk({req, " avail"}, rx_avail, 1);
    chk({req, " data"}, rd_data, d);
    chk({req, " break"}, rd_break, brk);
    chk({req, " frame"}, rd_frame_err, fe);
    chk({req, " parity"}, rd_parity_err, pe);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 avail", rx_avail, 0);
    chk("R11 level", fifo_level, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 rts", rts, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 sweep over lengths and parity modes
    for (int len = 0; len < 4; len++) begin
      for (int pm = 0; pm < 3; pm++) begin
        len_sel = 2'(len);
        parity_on = (pm != 0);
        parity_odd = (pm == 2);
        for (int k = 0; k < 6; k++) begin
          int v, nb;
          bit bad;
          nb = len + 5;
          v = ((k * 53 + len * 29 + pm * 7 + 11) & 8'hFF) & ((1 << nb) - 1);
          bad = (pm != 0) && (k == 3);
          send(v, nb, pm, bad, 1'b1);
          pop_check(bad ? "R2" : "R1", v, 0, 0, bad ? 1 : 0);
          chk("R1 one entry", rx_avail, 0);
        end
      end
    end

    // R4 framing error
    len_sel = 2'd3; parity_on = 1'b0;
    send(8'h5A, 8, 0, 1'b0, 1'b0);
    pop_check("R4", 8'h5A, 0, 1, 0);
    chk("R4 no extra", rx_avail, 0);

    // R3 start glitch rejected
    drive_bit(1'b0, 8);
    drive_bit(1'b1, 80);
    chk("R3 glitch ignored", rx_avail, 0);
    send(8'hC3, 8, 0, 1'b0, 1'b1);
    pop_check("R3 after glitch", 8'hC3, 0, 0, 0);

    // R5 break with parity configured
    parity_on = 1'b1; parity_odd = 1'b0;
    drive_bit(1'b0, BITCLK * 11 + 16);
    chk("R5 break stored", fifo_level, 1);
    drive_bit(1'b0, BITCLK * 12);
    chk("R5 held low no new entry", fifo_level, 1);
    drive_bit(1'b1, BITCLK * 2);
    chk("R5 still one entry", fifo_level, 1);
    pop_check("R5", 0, 1, 0, 0);
    send(8'h81, 8, 1, 1'b0, 1'b1);
    pop_check("R5 after break", 8'h81, 0, 0, 0);

    // R7 R8 single holding entry
    parity_on = 1'b0;
    fifo_on = 1'b0;
    ovr_seen = 0;
    send(8'h11, 8, 0, 1'b0, 1'b1);
    send(8'h22, 8, 0, 1'b0, 1'b1);
    chk("R7 level", fifo_level, 1);
    chk("R8 overrun pulse", ovr_seen, 1);
    pop_check("R7", 8'h11, 0, 0, 0);
    chk("R7 empty", rx_avail, 0);

    // R6 R8 R9 fill 64 entries with auto flow control
    fifo_on = 1'b1;
    auto_rts = 1'b1;
    len_sel = 2'd0;
    ovr_seen = 0;
    @(negedge clk);
    for (int i = 1; i <= 64; i++) begin
      send((i * 7 + 3) & 31, 5, 0, 1'b0, 1'b1);
      chk("R6 level", fifo_level, i);
      chk("R9 rts fill", rts, (i >= 60) ? 0 : 1);
    end
    send(5'h1F, 5, 0, 1'b0, 1'b1);
    chk("R8 full level", fifo_level, 64);
    chk("R8 full pulse", ovr_seen, 1);
    for (int i = 1; i <= 64; i++) begin
      pop_check("R6 order", (i * 7 + 3) & 31, 0, 0, 0);
      chk("R9 rts drain", rts, ((64 - i) < 56) ? 1 : 0);
    end
    chk("R6 empty", rx_avail, 0);

    // R9 auto off
    auto_rts = 1'b0;
    @(negedge clk);
    chk("R9 auto off", rts, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule